// File: doc/BRIEF.md
# Channel Status Block Receiver

This block sits behind a digital-audio line decoder. For each decoded frame it receives the channel-status bit and a code for the preamble type, and it builds the 192-bit channel-status block in a page of six 32-bit words. It also keeps three sticky event flags: a whole block has been captured, a block-start preamble has been seen, and a preamble was bad or missing. Software clears each flag by writing a 1 to its position, and each flag has its own interrupt enable.

Frames arrive on a valid/ready stream. The block has no reason to stall, so `frm_ready` is held high out of reset. The line decoder may hold `frm_valid` for as many cycles as it likes, and each cycle with `frm_valid` high counts as one frame. The page is visible all at once on a flat bus, and one word at a time through an addressed combinational read port.

Top module: `cs_block_rx`

## Requirements
- R1: `frm_ready` is 1 in every cycle after reset. A cycle with `frm_valid` high while `rx_en` is high consumes exactly one frame.
- R2: Bit index k is the number of capturing frames since the last block-start frame, with the block-start frame itself as k=0. Bit k is written to word k/32, bit k%32, where word 0 is the first word. After index 191 the next bit goes to index 0, even without a new block start.
- R3: Preamble code 1 (block start) stores its bit at word 0 bit 0 and moves the pointer to 1. It also sets status bit 1.
- R4: Preamble codes 0 and 3 (bad or missing) set status bit 2. The bit is discarded, the page is left unchanged and the pointer holds.
- R5: Status bit 0 (block done) is set when a code-2 frame writes index 191. It is not set by any earlier index.
- R6: The status flags are sticky. A cycle with `clr_we` high clears each flag whose `clr_mask` bit is 1. Flags whose mask bit is 0 keep their value.
- R7: If a set event and a clear of the same flag fall in the same cycle, the flag stays 1.
- R8: `irq` is 1 exactly when (`sts` AND `irq_en`) is nonzero, using the same bit positions as `sts`.
- R9: While `rx_en` is 0, frames capture nothing, set no flag and do not move the pointer.
- R10: For `rd_addr` 0 to 5, `rd_data` returns that word of the page in the same cycle. For addresses 6 and 7 it returns 0.
- R11: After reset, all six words are 0, all flags are 0, `irq` is 0 and the pointer is at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| frm_valid | input | 1 | Frame strobe (stream valid) |
| frm_ready | output | 1 | Stream ready, always 1 |
| frm_cbit | input | 1 | Channel-status bit of the frame |
| frm_pre | input | 2 | Preamble code: 0 bad, 1 block start, 2 ordinary frame, 3 bad |
| rd_addr | input | 3 | Word select for the read port |
| rd_data | output | 32 | Selected page word |
| cs_words | output | 192 | Whole page, word 0 in bits 31:0 |
| clr_we | input | 1 | Clear strobe for status |
| clr_mask | input | 3 | Write-one-to-clear mask |
| irq_en | input | 3 | Interrupt enable per flag |
| sts | output | 3 | Sticky flags: bit0 done, bit1 block start, bit2 bad preamble |
| irq | output | 1 | Interrupt request |

## Verification
A pointer that slips or fails to wrap puts a bit into the wrong word. That error appears at the read port and on the flat bus in the cycle after the frame edge. The bench compares every word after whole blocks with arithmetic bit patterns, so such an error is caught within that block. A completion flag that fires one frame early or late is visible on `sts[0]` right after the frame concerned, and the bench checks the flag both just before and just after index 191. Errors in the pointer hold during disabled or bad frames appear at the port only on the next good frame. For that reason each of those cases is followed by a capture into a bit position the bench predicts.

// File: rtl/cs_rx_pkg.sv
package cs_rx_pkg;
  localparam int PRE_W  = 2;
  localparam int NFLAGS = 3;

  typedef enum logic [PRE_W-1:0] {
    PRE_BAD_LO = 2'd0,
    PRE_BLOCK  = 2'd1,
    PRE_FRAME  = 2'd2,
    PRE_BAD_HI = 2'd3
  } pre_t;

  localparam int FLG_DONE = 0;
  localparam int FLG_BLK  = 1;
  localparam int FLG_BAD  = 2;
endpackage

// File: rtl/cs_rx_ptr.sv
module cs_rx_ptr #(
  parameter int TOTAL_BITS = 192,
  localparam int PTR_W = $clog2(TOTAL_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             is_blk,
  input  logic             is_frm,
  output logic [PTR_W-1:0] wr_idx,
  output logic             wr_en,
  output logic             done_evt
);
  logic [PTR_W-1:0] ptr_q;
  logic             at_last;

  assign at_last  = (ptr_q == PTR_W'(TOTAL_BITS - 1));
  assign wr_idx   = is_blk ? '0 : ptr_q;
  assign wr_en    = take & (is_blk | is_frm);
  assign done_evt = take & is_frm & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take && is_blk) begin
      ptr_q <= PTR_W'(1);
    end else if (take && is_frm) begin
      ptr_q <= at_last ? '0 : ptr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/cs_rx_page.sv
module cs_rx_page #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  parameter int IDX_W     = 8,
  parameter int ADDR_W    = 3,
  localparam int BIT_W = $clog2(WORD_W),
  localparam int SEL_W = IDX_W - BIT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_bit,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  output logic [NUM_WORDS*WORD_W-1:0] flat
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  logic [SEL_W-1:0]  word_sel;
  logic [BIT_W-1:0]  bit_sel;

  assign word_sel = wr_idx[IDX_W-1:BIT_W];
  assign bit_sel  = wr_idx[BIT_W-1:0];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[g] <= '0;
      end else if (wr_en && word_sel == SEL_W'(g)) begin
        words[g][bit_sel] <= wr_bit;
      end
    end
    assign flat[g*WORD_W +: WORD_W] = words[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = words[i];
    end
  end
endmodule

// File: rtl/cs_rx_flags.sv
module cs_rx_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] irq_en,
  output logic [N-1:0] sts,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_eff) | set_evt;
  end

  assign irq = |(sts & irq_en);
endmodule

// File: rtl/cs_block_rx.sv
module cs_block_rx
  import cs_rx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6,
  parameter int ADDR_W    = 3,
  localparam int TOTAL_BITS = WORD_W * NUM_WORDS,
  localparam int IDX_W      = $clog2(TOTAL_BITS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_en,
  input  logic                        frm_valid,
  output logic                        frm_ready,
  input  logic                        frm_cbit,
  input  logic [1:0]                  frm_pre,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [WORD_W-1:0]           rd_data,
  output logic [NUM_WORDS*WORD_W-1:0] cs_words,
  input  logic                        clr_we,
  input  logic [2:0]                  clr_mask,
  input  logic [2:0]                  irq_en,
  output logic [2:0]                  sts,
  output logic                        irq
);
  pre_t             pre;
  logic             take, is_blk, is_frm, is_bad;
  logic             wr_en, done_evt;
  logic [IDX_W-1:0] wr_idx;
  logic [NFLAGS-1:0] set_evt;

  assign frm_ready = 1'b1;
  assign pre    = pre_t'(frm_pre);
  assign take   = frm_valid & frm_ready & rx_en;
  assign is_blk = (pre == PRE_BLOCK);
  assign is_frm = (pre == PRE_FRAME);
  assign is_bad = (pre == PRE_BAD_LO) || (pre == PRE_BAD_HI);

  always_comb begin
    set_evt           = '0;
    set_evt[FLG_DONE] = done_evt;
    set_evt[FLG_BLK]  = take & is_blk;
    set_evt[FLG_BAD]  = take & is_bad;
  end

  cs_rx_ptr #(.TOTAL_BITS(TOTAL_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .take(take), .is_blk(is_blk), .is_frm(is_frm),
    .wr_idx(wr_idx), .wr_en(wr_en), .done_evt(done_evt)
  );

  cs_rx_page #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
               .ADDR_W(ADDR_W)) u_page (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_bit(frm_cbit), .rd_addr(rd_addr), .rd_data(rd_data), .flat(cs_words)
  );

  cs_rx_flags #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_we(clr_we),
    .clr_mask(clr_mask), .irq_en(irq_en), .sts(sts), .irq(irq)
  );
endmodule

// File: rtl/cs_rx_chk.sv
module cs_rx_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rx_en,
  input logic                        frm_valid,
  input logic                        frm_cbit,
  input logic [1:0]                  frm_pre,
  input logic [NUM_WORDS*WORD_W-1:0] cs_words,
  input logic                        clr_we,
  input logic [2:0]                  clr_mask,
  input logic [2:0]                  sts
);
  assert_blk_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && rx_en && frm_pre == 2'd1) |=> sts[1]);

  assert_blk_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && rx_en && frm_pre == 2'd1) |=> (cs_words[0] == $past(frm_cbit)));

  assert_bad_keeps_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && rx_en && (frm_pre == 2'd0 || frm_pre == 2'd3))
      |=> (sts[2] && $stable(cs_words)));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !(clr_we && clr_mask[0])) |=> sts[0]);

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && rx_en && frm_pre == 2'd1 && clr_we && clr_mask[1]) |=> sts[1]);

  assert_disabled_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(cs_words));

  assert_disabled_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !clr_we) |=> $stable(sts));
endmodule

bind cs_block_rx cs_rx_chk #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
  .frm_cbit(frm_cbit), .frm_pre(frm_pre), .cs_words(cs_words),
  .clr_we(clr_we), .clr_mask(clr_mask), .sts(sts)
);

// File: tb/tb_cs_block_rx.sv
module tb_cs_block_rx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_en = 1'b0;
  logic         frm_valid = 1'b0;
  logic         frm_ready;
  logic         frm_cbit = 1'b0;
  logic [1:0]   frm_pre = 2'd2;
  logic [2:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [191:0] cs_words;
  logic         clr_we = 1'b0;
  logic [2:0]   clr_mask = '0;
  logic [2:0]   irq_en = '0;
  logic [2:0]   sts;
  logic         irq;

  logic [31:0] mw [6];
  int          mptr;
  logic [2:0]  mfl;
  int          nchk = 0;
  int          nerr = 0;
  bit          done_flag = 0;

  always #10 clk = ~clk;

  cs_block_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frm_valid(frm_valid),
    .frm_ready(frm_ready), .frm_cbit(frm_cbit), .frm_pre(frm_pre),
    .rd_addr(rd_addr), .rd_data(rd_data), .cs_words(cs_words),
    .clr_we(clr_we), .clr_mask(clr_mask), .irq_en(irq_en), .sts(sts), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int k, input int seed);
    return ((k * seed + k / 3) % 5) < 2;
  endfunction

  task automatic send(input logic [1:0] pre, input logic c, input logic [2:0] clr);
    @(negedge clk);
    frm_valid = 1'b1; frm_pre = pre; frm_cbit = c;
    clr_we = |clr; clr_mask = clr;
    mfl = mfl & ~clr;
    if (rx_en) begin
      if (pre == 2'd1) begin
        mw[0][0] = c; mptr = 1; mfl[1] = 1'b1;
      end else if (pre == 2'd2) begin
        mw[mptr / 32][mptr % 32] = c;
        if (mptr == 191) begin mfl[0] = 1'b1; mptr = 0; end
        else mptr++;
      end else begin
        mfl[2] = 1'b1;
      end
    end
    @(negedge clk);
    frm_valid = 1'b0; clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m; mfl = mfl & ~m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic check_words(input string tag);
    for (int i = 0; i < 6; i++) begin
      rd_addr = 3'(i);
      #1;
      chk(tag, rd_data, mw[i]);
      chk(tag, cs_words[i*32 +: 32], mw[i]);
    end
  endtask

  task automatic check_sts(input string tag);
    chk(tag, {29'd0, sts}, {29'd0, mfl});
    chk(tag, {31'd0, irq}, {31'd0, |(mfl & irq_en)});
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 6; i++) mw[i] = '0;
    mptr = 0; mfl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R1 ready
    check_words("R11 reset page");
    check_sts("R11 reset flags");
    chk("R1 ready", {31'd0, frm_ready}, 32'd1);

    // R2 R3 R5 full block aligned by a block start
    rx_en = 1'b1;
    send(2'd1, 1'b1, 3'd0);
    chk("R3 block flag", {29'd0, sts}, 32'd2);
    for (int k = 1; k < 191; k++) send(2'd2, pat(k, 7), 3'd0);
    check_sts("R5 not done before index 191");
    send(2'd2, 1'b1, 3'd0);
    check_sts("R5 done at index 191");
    check_words("R2 block one");

    // R8 interrupt enables
    chk("R8 irq masked", {31'd0, irq}, 32'd0);
    irq_en = 3'b001; #1;
    chk("R8 irq done enabled", {31'd0, irq}, 32'd1);
    irq_en = 3'b100; #1;
    chk("R8 irq other enabled", {31'd0, irq}, 32'd0);
    irq_en = 3'b111;

    // R6 clear only the masked flag
    clear(3'b001);
    check_sts("R6 clear done only");

    // R2 wrap without block start: next frame lands at index 0
    send(2'd2, 1'b0, 3'd0);
    check_words("R2 wrap to index 0");
    chk("R2 wrap word0 bit0", {31'd0, rd_data[0] & 1'b0} | {31'd0, cs_words[0]}, 32'd0);

    // R9 disabled receiver
    rx_en = 1'b0;
    send(2'd2, 1'b1, 3'd0);
    send(2'd1, 1'b0, 3'd0);
    send(2'd0, 1'b1, 3'd0);
    check_words("R9 page held");
    check_sts("R9 flags held");
    rx_en = 1'b1;
    send(2'd2, 1'b1, 3'd0);
    check_words("R9 pointer held");

    // R4 bad preambles, both codes
    clear(3'b111);
    send(2'd0, 1'b1, 3'd0);
    check_sts("R4 bad code 0");
    clear(3'b100);
    send(2'd3, 1'b1, 3'd0);
    check_sts("R4 bad code 3");
    check_words("R4 page unchanged");
    send(2'd2, 1'b1, 3'd0);
    check_words("R4 pointer held");

    // R3 mid-block restart
    for (int k = 0; k < 10; k++) send(2'd2, 1'b1, 3'd0);
    send(2'd1, 1'b0, 3'd0);
    send(2'd2, 1'b0, 3'd0);
    check_words("R3 restart at index 0");

    // R7 set and clear in the same cycle
    send(2'd1, 1'b1, 3'b010);
    check_sts("R7 set wins over clear");

    // R10 unused addresses
    for (int a = 6; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R10 unused address", rd_data, 32'd0);
    end

    // R2 R5 second block with another pattern
    clear(3'b111);
    send(2'd1, 1'b0, 3'd0);
    for (int k = 1; k < 192; k++) send(2'd2, pat(k, 13), 3'd0);
    check_sts("R5 second block done");
    check_words("R2 block two");

    finish_run();
  end
endmodule